// File: doc/BRIEF.md
# Acquisition Storage Qualifier

This block sits between the sampling front end and acquisition memory. For every valid data word it decides whether that word is written. The decision comes from three layers. A global storage state can be switched on or off by trigger logic. A storage command attached to the current sequencer state overrides that global state. A command attached to a single event overrides both.

A block mode widens one stored event into a window. A store event then also writes the 31 valid samples before it and the 31 valid samples after it. To make the earlier samples available, the stream always passes through a 31-sample history line, so output sample n is input sample n-31. Windows that touch or overlap form one continuous written stretch, and each sample still appears only once.

Block mode cannot be used while violation-information storage is on. If both are requested, the block request is ignored and an error flag is raised.

Top module: `store_qualifier`

## Requirements
- R1: During reset and on the first clock after it, `out_valid` and `out_we` are 0. The global storage state takes the value `cfg_start_on` has while reset is asserted.
- R2: Each accepted input word (`in_valid`=1) comes out on `out_data` with `out_valid`=1 on the clock of the 31st later accepted input. The first 31 accepted inputs after reset produce no `out_valid`.
- R3: When both command inputs are "none", a sample is written exactly when the global storage state is on. Command encoding for `st_cmd` and `ev_cmd`: 2'b01 = store, 2'b10 = do not store, 2'b00 or 2'b11 = none.
- R4: `g_set` switches the global state on and `g_clr` switches it off. Either takes effect from the next accepted sample. If both are high, on wins.
- R5: A state command other than "none" decides the sample, whatever the global state is.
- R6: An event command other than "none" decides the sample, whatever the state command and the global state are. Outside block mode it affects only that one sample.
- R7: In block mode (`cfg_block`=1, `cfg_viol`=0), a sample with `ev_cmd`=store causes that sample, the 31 accepted samples before it and the 31 after it to be written. Inside such a window this holds even against a do-not-store command.
- R8: Overlapping windows merge. Every accepted sample is output once, with at most one write.
- R9: With `cfg_block`=1 and `cfg_viol`=1, `err_flag` is 1 and storage behaves as outside block mode. Otherwise `err_flag` is 0.
- R10: A cycle with `in_valid`=0 produces `out_valid`=0 and `out_we`=0 on the next clock, and it does not advance the history line or the window.
- R11: `out_we` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_on | input | 1 | Initial global storage state, loaded in reset |
| cfg_block | input | 1 | Block mode request |
| cfg_viol | input | 1 | Violation-information storage is on |
| in_valid | input | 1 | Input word is a valid sample |
| in_data | input | DW | Sample word |
| g_set | input | 1 | Turn global storage on |
| g_clr | input | 1 | Turn global storage off |
| st_cmd | input | 2 | Storage command of the current sequencer state |
| ev_cmd | input | 2 | Storage command of the current event |
| out_valid | output | 1 | Delayed sample present |
| out_data | output | DW | Delayed sample word |
| out_we | output | 1 | Write the delayed sample to memory |
| err_flag | output | 1 | Block mode requested while violation storage is on |

## Verification
The hard case is a sample whose own, undelayed decision says "do not store" while it also lies inside a block window opened by a store event up to 31 samples away on either side. Both rules then meet on a single output cycle. The bench provokes this by placing a do-not-store event between two store events whose windows overlap. It judges each output against a window computed from its own record of event positions: a sample counts as written if any store event lies within 31 positions of it. Stall cycles are placed inside windows as well, to show that windows count samples and not clocks.

// File: rtl/store_qualifier.sv
module store_qualifier #(
  parameter int DW   = 16,
  parameter int PRE  = 31,
  parameter int POST = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start_on,
  input  logic          cfg_block,
  input  logic          cfg_viol,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          g_set,
  input  logic          g_clr,
  input  logic [1:0]    st_cmd,
  input  logic [1:0]    ev_cmd,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_we,
  output logic          err_flag
);
  localparam int WIN = PRE + POST;
  localparam int CW  = $clog2(WIN + 1);
  localparam int FW  = $clog2(PRE + 1);
  localparam logic [1:0] CMD_STORE = 2'b01;
  localparam logic [1:0] CMD_SKIP  = 2'b10;

  logic          glob_q;
  logic [FW-1:0] fill;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dl_data [PRE];
  logic [PRE-1:0] dl_dec;
  logic          dec;

  wire blk_en   = cfg_block & ~cfg_viol;
  wire full     = (fill == FW'(PRE));
  wire ev_store = (ev_cmd == CMD_STORE);
  wire cov      = blk_en & (ev_store | (cnt != '0));

  assign err_flag = cfg_block & cfg_viol;

  always_comb begin
    dec = glob_q;
    if (st_cmd == CMD_STORE)     dec = 1'b1;
    else if (st_cmd == CMD_SKIP) dec = 1'b0;
    if (ev_cmd == CMD_STORE)     dec = 1'b1;
    else if (ev_cmd == CMD_SKIP) dec = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q    <= cfg_start_on;
      fill      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_data  <= '0;
      dl_dec    <= '0;
      for (int j = 0; j < PRE; j++) dl_data[j] <= '0;
    end else begin
      out_valid <= in_valid & full;
      out_we    <= in_valid & full & (dl_dec[PRE-1] | cov);
      if (in_valid) begin
        out_data   <= dl_data[PRE-1];
        dl_data[0] <= in_data;
        for (int j = 1; j < PRE; j++) dl_data[j] <= dl_data[j-1];
        dl_dec <= {dl_dec[PRE-2:0], dec};
        if (!full) fill <= fill + FW'(1);
        if (g_set)      glob_q <= 1'b1;
        else if (g_clr) glob_q <= 1'b0;
        if (blk_en && ev_store) cnt <= CW'(WIN);
        else if (cnt != '0)     cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/store_qualifier_chk.sv
module store_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] ev_cmd,
  input logic       cfg_block,
  input logic       cfg_viol,
  input logic       out_valid,
  input logic       out_we
);
  // R11
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);

  // R10
  stall_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we));

  // R2
  output_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R7
  block_event_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_cmd == 2'b01 && cfg_block && !cfg_viol) |=> (!out_valid || out_we));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && !out_we));
endmodule

bind store_qualifier store_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ev_cmd(ev_cmd),
  .cfg_block(cfg_block), .cfg_viol(cfg_viol),
  .out_valid(out_valid), .out_we(out_we)
);

// File: tb/tb_store_qualifier.sv
`timescale 1ns/1ps
module tb_store_qualifier;
  localparam int DW = 16;
  localparam int LAT = 31;
  localparam int HMAX = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start_on = 1'b1, cfg_block = 1'b0, cfg_viol = 1'b0;
  logic in_valid = 1'b0, g_set = 1'b0, g_clr = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [1:0] st_cmd = 2'b00, ev_cmd = 2'b00;
  logic out_valid, out_we, err_flag;
  logic [DW-1:0] out_data;

  store_qualifier dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_on(cfg_start_on), .cfg_block(cfg_block),
    .cfg_viol(cfg_viol), .in_valid(in_valid), .in_data(in_data), .g_set(g_set),
    .g_clr(g_clr), .st_cmd(st_cmd), .ev_cmd(ev_cmd), .out_valid(out_valid),
    .out_data(out_data), .out_we(out_we), .err_flag(err_flag)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, nsent = 0, nwr = 0, phase = 0;
  logic done = 1'b0, gm = 1'b0, blk_mode = 1'b0;
  logic [DW-1:0] data_h [HMAX];
  logic dexp_h [HMAX];
  logic evs_h [HMAX];

  // {g_set, g_clr, st_cmd, ev_cmd, expected write}; start state on
  localparam logic [6:0] TBL [16] = '{
    7'b00_00_00_1, // R3 global on
    7'b01_00_00_1, // R4 clear acts from next sample
    7'b00_00_00_0, // R3 global off
    7'b00_01_00_1, // R5 state store
    7'b00_10_00_0, // R5 state skip
    7'b00_00_01_1, // R6 event store, single sample
    7'b00_10_01_1, // R6 event beats state
    7'b00_01_10_0, // R6 event skip beats state store
    7'b00_11_11_0, // R3 code 11 is none
    7'b11_00_00_0, // R4 both: set wins, from next
    7'b00_00_00_1, // R4
    7'b00_10_00_0, // R5
    7'b00_01_00_1, // R5
    7'b00_00_10_0, // R6
    7'b10_10_01_1, // R6
    7'b01_01_10_0  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic dec_model(input logic [1:0] st, input logic [1:0] ev);
    if (ev == 2'b01) return 1'b1;
    if (ev == 2'b10) return 1'b0;
    if (st == 2'b01) return 1'b1;
    if (st == 2'b10) return 1'b0;
    return gm;
  endfunction

  function automatic logic exp_we(input int o);
    logic r = dexp_h[o];
    if (blk_mode)
      for (int e = o - LAT; e <= o + LAT; e++)
        if (e >= 0 && evs_h[e]) r = 1'b1;
    return r;
  endfunction

  task automatic do_reset(input logic start_on, input logic blk, input logic viol);
    rst_n = 1'b0; in_valid = 1'b0;
    cfg_start_on = start_on; cfg_block = blk; cfg_viol = viol;
    for (int i = 0; i < HMAX; i++) begin dexp_h[i] = 0; evs_h[i] = 0; data_h[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", 32'(out_valid), 0);
    check("R1 out_we in reset", 32'(out_we), 0);
    rst_n = 1'b1;
    gm = start_on; blk_mode = blk & ~viol; nsent = 0; nwr = 0; phase++;
    @(posedge clk); #1;
    check("R1 out_valid after reset", 32'(out_valid), 0);
  endtask

  task automatic send(input logic gs, input logic gc, input logic [1:0] st,
                      input logic [1:0] ev, input logic dexp);
    logic [DW-1:0] d = DW'(nsent * 7 + phase * 1000);
    in_valid = 1'b1; g_set = gs; g_clr = gc; st_cmd = st; ev_cmd = ev; in_data = d;
    data_h[nsent] = d; dexp_h[nsent] = dexp; evs_h[nsent] = (ev == 2'b01);
    @(posedge clk); #1;
    if (nsent >= LAT) begin
      check("R2 out_valid", 32'(out_valid), 1);
      check("R2 out_data", 32'(out_data), 32'(data_h[nsent - LAT]));
      check(blk_mode ? "R7 block write" : "R6 layered write", 32'(out_we),
            32'(exp_we(nsent - LAT)));
      if (out_we) nwr++;
    end else begin
      check("R2 no output while filling", 32'(out_valid), 0);
    end
    if (gs) gm = 1'b1; else if (gc) gm = 1'b0;
    nsent++;
    in_valid = 1'b0; g_set = 0; g_clr = 0; st_cmd = 0; ev_cmd = 0;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R10 stall out_valid", 32'(out_valid), 0);
    check("R10 stall out_we", 32'(out_we), 0);
  endtask

  task automatic check_total(input string tag);
    int ew = 0;
    for (int o = 0; o + LAT < nsent; o++) if (exp_we(o)) ew++;
    check(tag, 32'(nwr), 32'(ew));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Phase 1: priority table, non-block, start on
    do_reset(1'b1, 1'b0, 1'b0);
    check("R9 err_flag clear", 32'(err_flag), 0);
    for (int i = 0; i < 16; i++)
      send(TBL[i][6], TBL[i][5], TBL[i][4:3], TBL[i][2:1], TBL[i][0]);
    for (int i = 0; i < 40; i++) send(0, 0, 2'b00, 2'b00, gm);
    check_total("R3 write count phase 1");

    // Phase 2: block mode, start off (R3), merging windows (R8), stalls (R10)
    do_reset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 220; i++) begin
      logic [1:0] st = (i == 5) ? 2'b01 : 2'b00;
      logic [1:0] ev = (i == 40 || i == 60 || i == 150) ? 2'b01 :
                       (i == 50) ? 2'b10 : 2'b00;
      if (i % 37 == 36) idle();
      send(0, 0, st, ev, dec_model(st, ev));
    end
    idle();
    check_total("R8 merged window write count");

    // Phase 3: block requested with violation storage on
    do_reset(1'b1, 1'b1, 1'b1);
    check("R9 err_flag set", 32'(err_flag), 1);
    send(0, 1, 2'b00, 2'b00, 1'b1);
    for (int i = 1; i < 90; i++) begin
      logic [1:0] ev = (i == 40) ? 2'b01 : 2'b00;
      send(0, 0, 2'b00, ev, dec_model(2'b00, ev));
    end
    check_total("R9 single-sample write only");
    finish_run();
  end
endmodule